// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers completion and error events for an SD host controller and turns them into a single interrupt line. Two one-cycle event sources feed it: command completion and transfer completion from the command and data engines, plus ten error event lines. Every event is latched only when its status-enable bit is set. It drives the interrupt only when its signal-enable bit is also set. Software clears the latched bits by writing ones.

Two more functions sit in the same block. One is a pair of line resets that clear themselves: a command-line reset and a data-line reset. Each clears the status and inhibit state of its own line. The other is a present-state word. It carries the command and data inhibit flags, and it resolves a transfer outcome in which transfer complete wins over a data timeout that is latched at the same time.

Top module: `sdh_irq_unit`

## Requirements
- R1: Events are latched only when their status-enable bit is set. In the normal status word (address 0), command complete is bit 0 and transfer complete is bit 1. In the error status word (address 1), bits 0 to 9 are, in order: command timeout, command CRC, command end bit, command index, data timeout, data CRC, data end bit, current limit, auto-stop-command error and descriptor DMA error. The event is visible on the cycle after its pulse.
- R2: Writing 1 to a bit of address 0 or address 1 clears that bit. Writing 0 leaves the bit unchanged. When an enabled event and a clear fall in the same cycle, the event wins.
- R3: Bit 15 of address 0 reads 1 exactly when any error status bit is set. Writes to bit 15 have no effect. It clears only when every error bit is cleared.
- R4: `irq` is high when any normal status bit [1:0] has its signal-enable bit set at address 4, or any error status bit has its signal-enable bit set at address 5.
- R5: Present-state bit 2 (address 7) reads 1 while transfer complete is set. Bit 3 reads 1 only while data timeout is set and transfer complete is clear.
- R6: Writing 1 to bit 0 (command) or bit 1 (data) of address 6 starts that line's reset. The bit reads 1 for RST_CYCLES (4) cycles and then clears by itself.
- R7: While the command reset bit is 1, command complete, error bits 0 to 3 and the command inhibit are held at 0, and events for them are ignored. While the data reset bit is 1, the same holds for transfer complete, error bits 4, 5, 6, 8 and 9 and the data inhibit. Current limit is cleared by neither reset.
- R8: `cmd_start` sets command inhibit (address 7 bit 0). It is cleared by a command-complete pulse or by any command error pulse (error bits 0 to 3), whatever the enables. `dat_start` sets data inhibit (bit 1). It is cleared by a transfer-complete pulse or by any data error pulse (bits 4, 5, 6, 8, 9). A start in the same cycle as a clearing pulse leaves the flag set.
- R9: The enable registers read back what was written: addresses 2 and 4 in bits [1:0], addresses 3 and 5 in bits [9:0]. All bits that are not defined read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cmd_done | input | 1 | Command completion pulse |
| ev_xfer_done | input | 1 | Transfer completion pulse |
| ev_err | input | 10 | Error event pulses, one per error bit |
| cmd_start | input | 1 | A command was issued |
| dat_start | input | 1 | A data transfer was started |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is sampled as a level on each clock edge, so a pulse held for two cycles counts as two events. They also assume that the write port never carries unknown values while `wr_en` is high. The random stimulus changes inputs only on the falling edge and holds each pulse for exactly one cycle. It spreads writes over all eight addresses, so resets, clears and enable changes land on top of live events. Directed sequences add the cases that need exact timing: transfer complete and data timeout arriving together, a clear colliding with an event, and events that arrive during a reset.

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit #(
  parameter int RST_CYCLES = 4,
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_cmd_done,
  input  logic        ev_xfer_done,
  input  logic [9:0]  ev_err,
  input  logic        cmd_start,
  input  logic        dat_start,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq
);
  localparam logic [9:0] CMD_ERR = 10'h00F;
  localparam logic [9:0] DAT_ERR = 10'h370;
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

  logic [1:0] nsts, nen, nsig;
  logic [9:0] ests, een, esig;
  logic       crst, drst, cinh, dinh;
  logic [CW-1:0] ccnt, dcnt;

  wire wr_nsts = wr_en && wr_addr == 3'd0;
  wire wr_ests = wr_en && wr_addr == 3'd1;
  wire wr_rst  = wr_en && wr_addr == 3'd6;

  wire [1:0] n_clr   = wr_nsts ? wr_data[1:0] : 2'b00;
  wire [9:0] e_clr   = wr_ests ? wr_data[9:0] : 10'd0;
  wire [9:0] e_hold  = ~((crst ? CMD_ERR : 10'd0) | (drst ? DAT_ERR : 10'd0));
  wire       cmd_fin = ev_cmd_done || |(ev_err & CMD_ERR);
  wire       dat_fin = ev_xfer_done || |(ev_err & DAT_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsts <= '0; ests <= '0;
      nen <= '0; een <= '0; nsig <= '0; esig <= '0;
      cinh <= 1'b0; dinh <= 1'b0;
    end else begin
      nsts <= ((nsts & ~n_clr) | ({ev_xfer_done, ev_cmd_done} & nen)) & ~{drst, crst};
      ests <= ((ests & ~e_clr) | (ev_err & een)) & e_hold;
      if (wr_en && wr_addr == 3'd2) nen  <= wr_data[1:0];
      if (wr_en && wr_addr == 3'd3) een  <= wr_data[9:0];
      if (wr_en && wr_addr == 3'd4) nsig <= wr_data[1:0];
      if (wr_en && wr_addr == 3'd5) esig <= wr_data[9:0];
      cinh <= !crst && (cmd_start || (cinh && !cmd_fin));
      dinh <= !drst && (dat_start || (dinh && !dat_fin));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crst <= 1'b0; drst <= 1'b0; ccnt <= '0; dcnt <= '0;
    end else begin
      if (wr_rst && wr_data[0]) begin
        crst <= 1'b1; ccnt <= CNT_LOAD;
      end else if (crst) begin
        if (ccnt == '0) crst <= 1'b0;
        else ccnt <= ccnt - 1'b1;
      end
      if (wr_rst && wr_data[1]) begin
        drst <= 1'b1; dcnt <= CNT_LOAD;
      end else if (drst) begin
        if (dcnt == '0) drst <= 1'b0;
        else dcnt <= dcnt - 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0: rd_data = {|ests, 13'd0, nsts};
      3'd1: rd_data[9:0] = ests;
      3'd2: rd_data[1:0] = nen;
      3'd3: rd_data[9:0] = een;
      3'd4: rd_data[1:0] = nsig;
      3'd5: rd_data[9:0] = esig;
      3'd6: rd_data[1:0] = {drst, crst};
      3'd7: rd_data[3:0] = {ests[4] && !nsts[1], nsts[1], dinh, cinh};
      default: rd_data = '0;
    endcase
  end

  assign irq = |(nsts & nsig) || |(ests & esig);

  a_r1_cmd_done_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && nen[0] && !crst) |=> nsts[0]);
  a_r1_disabled_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!een[0] && !ests[0]) |=> !ests[0]);
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ests && wr_data[5] && !(ev_err[5] && een[5])) |=> !ests[5]);
  a_r4_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (nsts != 2'b00 || ests != 10'd0));
  a_r7_cmd_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    crst |=> (ests[3:0] == 4'd0 && !nsts[0] && !cinh));
  a_r7_dat_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drst |=> ((ests & DAT_ERR) == 10'd0 && !nsts[1] && !dinh));
  a_r8_cmd_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !crst) |=> cinh);
endmodule

// File: tb/sdh_irq_unit_tb.sv
`timescale 1ns/100ps
module sdh_irq_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_cmd_done = 0, ev_xfer_done = 0, cmd_start = 0, dat_start = 0, wr_en = 0;
  logic [9:0] ev_err = '0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  sdh_irq_unit u_dut (.clk, .rst_n, .ev_cmd_done, .ev_xfer_done, .ev_err, .cmd_start,
    .dat_start, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .irq);

  localparam logic [9:0] CE = 10'h00F, DE = 10'h370;
  logic [1:0] m_n, m_nen, m_nsig;
  logic [9:0] m_e, m_een, m_esig;
  logic m_cr, m_dr, m_ci, m_di;
  int m_cc, m_dc;

  task automatic model_reset();
    m_n = 0; m_nen = 0; m_nsig = 0; m_e = 0; m_een = 0; m_esig = 0;
    m_cr = 0; m_dr = 0; m_ci = 0; m_di = 0; m_cc = 0; m_dc = 0;
  endtask

  task automatic model_step();
    logic [1:0] nn; logic [9:0] ne; logic cr, dr;
    cr = m_cr; dr = m_dr;
    nn = m_n & ~((wr_en && wr_addr == 0) ? wr_data[1:0] : 2'b0);
    nn = (nn | ({ev_xfer_done, ev_cmd_done} & m_nen)) & ~{dr, cr};
    ne = m_e & ~((wr_en && wr_addr == 1) ? wr_data[9:0] : 10'b0);
    ne = (ne | (ev_err & m_een)) & ~((cr ? CE : 10'd0) | (dr ? DE : 10'd0));
    if (wr_en && wr_addr == 2) m_nen = wr_data[1:0];
    if (wr_en && wr_addr == 3) m_een = wr_data[9:0];
    if (wr_en && wr_addr == 4) m_nsig = wr_data[1:0];
    if (wr_en && wr_addr == 5) m_esig = wr_data[9:0];
    m_ci = !cr && (cmd_start || (m_ci && !(ev_cmd_done || |(ev_err & CE))));
    m_di = !dr && (dat_start || (m_di && !(ev_xfer_done || |(ev_err & DE))));
    if (wr_en && wr_addr == 6 && wr_data[0]) begin m_cr = 1; m_cc = 4; end
    else if (m_cr) begin m_cc--; if (m_cc == 0) m_cr = 0; end
    if (wr_en && wr_addr == 6 && wr_data[1]) begin m_dr = 1; m_dc = 4; end
    else if (m_dr) begin m_dc--; if (m_dc == 0) m_dr = 0; end
    m_n = nn; m_e = ne;
  endtask

  function automatic logic [15:0] exp_rd(int a);
    case (a)
      0: return {|m_e, 13'd0, m_n};
      1: return {6'd0, m_e};
      2: return {14'd0, m_nen};
      3: return {6'd0, m_een};
      4: return {14'd0, m_nsig};
      5: return {6'd0, m_esig};
      6: return {14'd0, m_dr, m_cr};
      default: return {12'd0, m_e[4] && !m_n[1], m_n[1], m_di, m_ci};
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0, 1: return "R1";
      6: return "R6";
      7: return "R5/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #0.25;
      chk(tag_of(a), rd_data, exp_rd(a));
    end
    chk("R4 irq", {15'd0, irq}, {15'd0, |(m_n & m_nsig) || |(m_e & m_esig)});
  endtask

  task automatic step();
    @(posedge clk); model_step(); #1; check_all();
    @(negedge clk);
    ev_cmd_done = 0; ev_xfer_done = 0; ev_err = 0; cmd_start = 0; dat_start = 0; wr_en = 0;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d); step();
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    rd_addr = 3'(a); #0.25; chk(tag, rd_data, 16'(exp));
  endtask

  initial begin
    #200000; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7531;
    void'($urandom(seed));
    model_reset();
    #12; check_all();
    @(negedge clk); rst_n = 1;
    // R1: disabled events are not latched
    ev_err = 10'h3FF; ev_cmd_done = 1; ev_xfer_done = 1; step();
    rd_chk("R1 disabled", 1, 0);
    wr(2, 3); wr(3, 16'h3FF); wr(4, 3); wr(5, 16'h3FF);
    // R5 priority: transfer complete with data timeout
    ev_xfer_done = 1; ev_err = 10'h010; step();
    rd_chk("R5 both", 7, 4);
    rd_chk("R3 summary", 0, 16'h8002);
    wr(0, 16'h8002);
    rd_chk("R3 read-only", 0, 16'h8000);
    rd_chk("R5 timeout", 7, 8);
    // R2: event beats simultaneous clear
    wr_en = 1; wr_addr = 1; wr_data = 16'h0010; ev_err = 10'h010; step();
    rd_chk("R2 event wins", 1, 16'h0010);
    wr(1, 16'h0010);
    rd_chk("R2 cleared", 1, 0);
    rd_chk("R3 summary clear", 0, 0);
    // R7: command reset clears command side, ignores events, keeps current limit
    ev_err = 10'h08F; cmd_start = 1; step();
    wr(6, 1);
    ev_cmd_done = 1; ev_err = 10'h001; step();
    rd_chk("R7 cmd cleared", 1, 16'h0080);
    rd_chk("R6 busy", 6, 1);
    for (int i = 0; i < 4; i++) step();
    rd_chk("R6 done", 6, 0);
    wr(1, 16'h3FF);
    repeat (3000) begin
      ev_cmd_done = ($urandom % 5) == 0;
      ev_xfer_done = ($urandom % 5) == 0;
      for (int b = 0; b < 10; b++) ev_err[b] = ($urandom % 14) == 0;
      cmd_start = ($urandom % 6) == 0;
      dat_start = ($urandom % 6) == 0;
      if ($urandom % 3 == 0) begin
        wr_en = 1; wr_addr = 3'($urandom); wr_data = 16'($urandom);
        if (wr_addr == 6 && ($urandom % 4) != 0) wr_data = 0;
      end
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule